// File: doc/BRIEF.md
# Dual-Class Vectored Interrupt Controller

This block gathers 64 level-sensitive interrupt sources and presents them to a processor on two request lines. One line is for normal requests and the other is for fast requests. Each source has four pieces of state: a pending bit, an enable bit, a class bit that routes it to the fast line, and a 4-bit priority. Software reaches this state through a word-addressed register bus. Sources can be enabled and disabled one at a time by writing a source number. Software can also overwrite the pending vector directly, which is how it forces interrupts.

Gating on the normal line uses a 5-bit threshold. While the threshold is all ones, any effective normal source raises the line. At any other threshold value, a source counts only if its priority is strictly greater than the threshold. Two read-to-acknowledge registers return a source and clear its pending bit. The normal one returns the highest-priority normal source. The fast one returns the lowest-numbered fast source. A hardware input updates its pending bit whenever its level changes. Both request outputs are registered and follow the stored state with a one-cycle lag.

Top module: `vic_dual_class`

## Requirements
- R1: After reset, pending, enable, class, priorities and control are all zero, the threshold reads 0x1F, and both request outputs are low.
- R2: A change on src_i[n] copies the new level into pending bit n at the next clock edge. The request outputs reflect any state change one edge later. A level that stays constant does not re-set a bit that software has cleared.
- R3: A write to word 2 sets enable bit wdata[5:0], and a write to word 3 clears that bit. Words 2 and 3 both read as 0.
- R4: Words 4 and 5 hold the upper and lower halves of the enable vector. Words 6 and 7 hold the class vector, where 1 selects fast. Words 18 and 19 are read-only views of pending. A write to word 20 or 21 overwrites the upper or lower half of pending, and both words read 0.
- R5: irq_fast_o is high when some source is pending, enabled and of class 1.
- R6: irq_normal_o considers only sources that are pending, enabled and of class 0. With the threshold at 0x1F, any such source raises it. With any other threshold, the line rises only if one of them has a priority strictly greater than the threshold.
- R7: Priority word k covers sources 8k to 8k+7, 4 bits per source, with source 8k+j at bits 4j+3 to 4j. Word k sits at word address 15-k, so word 8 holds k=7 and word 15 holds k=0.
- R8: Word 1 stores only wdata[4:0] as the threshold. Word 0 keeps only bits 24, 22, 21, 20, 19 and 18 of the written value, so a write of all ones reads back as 0x017C0000.
- R9: Words 22 and 23 return the upper and lower halves of pending&enable&~class. Words 24 and 25 return the upper and lower halves of pending&enable&class. Writes to words 16 through 19 and 22 through 25 change nothing.
- R10: A read of word 16 returns (n<<16)|p for the normal effective source n with the highest priority p, picking the higher number on a tie, and clears pending bit n. With no candidate, it returns 0xFFFFFFFF.
- R11: A read of word 17 returns the lowest-numbered fast effective source and clears its pending bit. With no candidate, it returns 0xFFFFFFFF.
- R12: A read of word 0x40 returns 4. Writes to words 0x40 through 0xBF are ignored. Reads of any undecoded word return 0.
- R13: rdata_o presents the value addressed by a read one cycle after req_i and we_i=0. It reflects the state as it stood before any acknowledge side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 64 | Level interrupt sources |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | 8 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid one cycle after a read |
| irq_normal_o | output | 1 | Normal-class request |
| irq_fast_o | output | 1 | Fast-class request |

## Verification
A behavioural model predicts both request lines on every clock, and it also predicts every read value. Several stimulus patterns are used, and each one separates a different part of the logic. Forcing a single source and flipping its class separates the fast path from the normal path. Threshold values at, just below and equal to 0x1F separate the strict comparison from the bypass. Three sources, two of them sharing a priority, are acknowledged in turn to show the tie rule and the pending clear. Raising a hardware input shows the two-edge latency and the change-only update of pending.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int N_SRC   = 64;
  localparam int DW      = 32;
  localparam int AW      = 8;
  localparam int PRIO_W  = 4;
  localparam int MASK_W  = 5;
  localparam int IDX_W   = $clog2(N_SRC);
  localparam int PER_WD  = DW / PRIO_W;
  localparam int N_PWORD = N_SRC / PER_WD;
  localparam int PSEL_W  = $clog2(N_PWORD);

  localparam logic [AW-1:0] OFF_CTRL   = 8'd0;
  localparam logic [AW-1:0] OFF_MASK   = 8'd1;
  localparam logic [AW-1:0] OFF_ENNUM  = 8'd2;
  localparam logic [AW-1:0] OFF_DISNUM = 8'd3;
  localparam logic [AW-1:0] OFF_EN_HI  = 8'd4;
  localparam logic [AW-1:0] OFF_EN_LO  = 8'd5;
  localparam logic [AW-1:0] OFF_TY_HI  = 8'd6;
  localparam logic [AW-1:0] OFF_TY_LO  = 8'd7;
  localparam logic [AW-1:0] OFF_PR_LO  = 8'd8;
  localparam logic [AW-1:0] OFF_PR_HI  = 8'd15;
  localparam logic [AW-1:0] OFF_NVEC   = 8'd16;
  localparam logic [AW-1:0] OFF_FVEC   = 8'd17;
  localparam logic [AW-1:0] OFF_SRC_HI = 8'd18;
  localparam logic [AW-1:0] OFF_SRC_LO = 8'd19;
  localparam logic [AW-1:0] OFF_FRC_HI = 8'd20;
  localparam logic [AW-1:0] OFF_FRC_LO = 8'd21;
  localparam logic [AW-1:0] OFF_NP_HI  = 8'd22;
  localparam logic [AW-1:0] OFF_NP_LO  = 8'd23;
  localparam logic [AW-1:0] OFF_FP_HI  = 8'd24;
  localparam logic [AW-1:0] OFF_FP_LO  = 8'd25;
  localparam logic [AW-1:0] OFF_VEC0   = 8'h40;

  localparam logic [DW-1:0] CTRL_KEEP  = 32'h017C_0000;
  localparam logic [DW-1:0] VEC0_VAL   = 32'd4;
endpackage

// File: rtl/vic_arbiter.sv
module vic_arbiter
  import vic_pkg::*;
(
  input  logic [N_SRC-1:0]        norm_eff_i,
  input  logic [N_SRC-1:0]        fast_eff_i,
  input  logic [N_SRC*PRIO_W-1:0] prio_i,
  input  logic [MASK_W-1:0]       mask_i,
  output logic                    n_valid_o,
  output logic [IDX_W-1:0]        n_idx_o,
  output logic [PRIO_W-1:0]       n_prio_o,
  output logic                    n_gate_o,
  output logic                    f_valid_o,
  output logic [IDX_W-1:0]        f_idx_o
);
  logic above;

  // normal: highest priority, later index wins ties
  always_comb begin
    n_valid_o = 1'b0;
    n_idx_o   = '0;
    n_prio_o  = '0;
    above     = 1'b0;
    for (int i = 0; i < N_SRC; i++) begin
      if (norm_eff_i[i]) begin
        if (!n_valid_o || prio_i[i*PRIO_W +: PRIO_W] >= n_prio_o) begin
          n_valid_o = 1'b1;
          n_idx_o   = IDX_W'(i);
          n_prio_o  = prio_i[i*PRIO_W +: PRIO_W];
        end
        if ({1'b0, prio_i[i*PRIO_W +: PRIO_W]} > mask_i) above = 1'b1;
      end
    end
    n_gate_o = (mask_i == '1) ? |norm_eff_i : above;
  end

  // fast: lowest index
  always_comb begin
    f_valid_o = |fast_eff_i;
    f_idx_o   = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (fast_eff_i[i]) f_idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/vic_irq_out.sv
module vic_irq_out
  import vic_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] norm_eff_i,
  input  logic [N_SRC-1:0] fast_eff_i,
  input  logic             n_gate_i,
  output logic             irq_normal_o,
  output logic             irq_fast_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_normal_o <= 1'b0;
      irq_fast_o   <= 1'b0;
    end else begin
      irq_normal_o <= n_gate_i;
      irq_fast_o   <= |fast_eff_i;
    end
  end

  AST_FAST_HAS_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_fast_o |-> $past(|fast_eff_i)); // R5
  AST_FAST_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|fast_eff_i) |=> irq_fast_o); // R5
  AST_NORMAL_HAS_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_normal_o |-> $past(|norm_eff_i)); // R6
endmodule

// File: rtl/vic_regs.sv
module vic_regs
  import vic_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_SRC-1:0]        src_i,
  input  logic                    req_i,
  input  logic                    we_i,
  input  logic [AW-1:0]           addr_i,
  input  logic [DW-1:0]           wdata_i,
  input  logic                    n_valid_i,
  input  logic [IDX_W-1:0]        n_idx_i,
  input  logic [PRIO_W-1:0]       n_prio_i,
  input  logic                    f_valid_i,
  input  logic [IDX_W-1:0]        f_idx_i,
  output logic [N_SRC-1:0]        pend_o,
  output logic [N_SRC-1:0]        en_o,
  output logic [N_SRC-1:0]        typ_o,
  output logic [N_SRC*PRIO_W-1:0] prio_o,
  output logic [MASK_W-1:0]       mask_o,
  output logic [DW-1:0]           rdata_o
);
  logic [N_SRC-1:0] src_q, pend_d, en_d, chg;
  logic [DW-1:0]    ctrl_q, rd_val;
  logic             wr, rd, in_prio;
  logic [PSEL_W-1:0] psel;
  logic [N_SRC-1:0] n_eff, f_eff;

  assign wr      = req_i & we_i;
  assign rd      = req_i & ~we_i;
  assign in_prio = (addr_i >= OFF_PR_LO) && (addr_i <= OFF_PR_HI);
  assign psel    = PSEL_W'(OFF_PR_HI - addr_i);
  assign chg     = src_i ^ src_q;
  assign n_eff   = pend_o & en_o & ~typ_o;
  assign f_eff   = pend_o & en_o & typ_o;

  always_comb begin
    pend_d = (pend_o & ~chg) | (src_i & chg);
    if (wr && addr_i == OFF_FRC_HI) pend_d[DW +: DW] = wdata_i;
    if (wr && addr_i == OFF_FRC_LO) pend_d[0 +: DW]  = wdata_i;
    if (rd && addr_i == OFF_NVEC && n_valid_i) pend_d[n_idx_i] = 1'b0;
    if (rd && addr_i == OFF_FVEC && f_valid_i) pend_d[f_idx_i] = 1'b0;
  end

  always_comb begin
    en_d = en_o;
    if (wr && addr_i == OFF_ENNUM)  en_d[wdata_i[IDX_W-1:0]] = 1'b1;
    if (wr && addr_i == OFF_DISNUM) en_d[wdata_i[IDX_W-1:0]] = 1'b0;
    if (wr && addr_i == OFF_EN_HI)  en_d[DW +: DW] = wdata_i;
    if (wr && addr_i == OFF_EN_LO)  en_d[0 +: DW]  = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q  <= '0;
      pend_o <= '0;
      en_o   <= '0;
      typ_o  <= '0;
      prio_o <= '0;
      mask_o <= '1;
      ctrl_q <= '0;
    end else begin
      src_q  <= src_i;
      pend_o <= pend_d;
      en_o   <= en_d;
      if (wr) begin
        if (addr_i == OFF_TY_HI) typ_o[DW +: DW] <= wdata_i;
        if (addr_i == OFF_TY_LO) typ_o[0 +: DW]  <= wdata_i;
        if (addr_i == OFF_MASK)  mask_o <= wdata_i[MASK_W-1:0];
        if (addr_i == OFF_CTRL)  ctrl_q <= wdata_i & CTRL_KEEP;
        if (in_prio)             prio_o[psel*DW +: DW] <= wdata_i;
      end
    end
  end

  always_comb begin
    rd_val = '0;
    case (addr_i)
      OFF_CTRL:   rd_val = ctrl_q;
      OFF_MASK:   rd_val = DW'(mask_o);
      OFF_EN_HI:  rd_val = en_o[DW +: DW];
      OFF_EN_LO:  rd_val = en_o[0 +: DW];
      OFF_TY_HI:  rd_val = typ_o[DW +: DW];
      OFF_TY_LO:  rd_val = typ_o[0 +: DW];
      OFF_NVEC:   rd_val = n_valid_i ? {{(DW-16-IDX_W){1'b0}}, n_idx_i,
                                        {(16-PRIO_W){1'b0}}, n_prio_i} : '1;
      OFF_FVEC:   rd_val = f_valid_i ? {{(DW-IDX_W){1'b0}}, f_idx_i} : '1;
      OFF_SRC_HI: rd_val = pend_o[DW +: DW];
      OFF_SRC_LO: rd_val = pend_o[0 +: DW];
      OFF_NP_HI:  rd_val = n_eff[DW +: DW];
      OFF_NP_LO:  rd_val = n_eff[0 +: DW];
      OFF_FP_HI:  rd_val = f_eff[DW +: DW];
      OFF_FP_LO:  rd_val = f_eff[0 +: DW];
      OFF_VEC0:   rd_val = VEC0_VAL;
      default:    rd_val = in_prio ? prio_o[psel*DW +: DW] : '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_o <= '0;
    else if (rd)  rdata_o <= rd_val;
  end

  AST_ENNUM_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == OFF_ENNUM) |=> en_o[$past(wdata_i[IDX_W-1:0])]); // R3
  AST_DISNUM_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == OFF_DISNUM) |=> !en_o[$past(wdata_i[IDX_W-1:0])]); // R3
  AST_FORCE_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && (addr_i == OFF_FRC_LO || addr_i == OFF_FRC_HI)) |=> rdata_o == '0); // R4
  AST_MASK_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == OFF_MASK) |=> mask_o == $past(wdata_i[MASK_W-1:0])); // R8
endmodule

// File: rtl/vic_dual_class.sv
module vic_dual_class
  import vic_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [63:0]      src_i,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [7:0]       addr_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  output logic             irq_normal_o,
  output logic             irq_fast_o
);
  logic [N_SRC-1:0]        pend, en, typ, norm_eff, fast_eff;
  logic [N_SRC*PRIO_W-1:0] prio;
  logic [MASK_W-1:0]       mask;
  logic                    n_valid, n_gate, f_valid;
  logic [IDX_W-1:0]        n_idx, f_idx;
  logic [PRIO_W-1:0]       n_prio;

  assign norm_eff = pend & en & ~typ;
  assign fast_eff = pend & en & typ;

  vic_regs u_regs (
    .clk_i, .rst_ni, .src_i, .req_i, .we_i, .addr_i, .wdata_i,
    .n_valid_i(n_valid), .n_idx_i(n_idx), .n_prio_i(n_prio),
    .f_valid_i(f_valid), .f_idx_i(f_idx),
    .pend_o(pend), .en_o(en), .typ_o(typ), .prio_o(prio), .mask_o(mask),
    .rdata_o
  );

  vic_arbiter u_arb (
    .norm_eff_i(norm_eff), .fast_eff_i(fast_eff), .prio_i(prio), .mask_i(mask),
    .n_valid_o(n_valid), .n_idx_o(n_idx), .n_prio_o(n_prio), .n_gate_o(n_gate),
    .f_valid_o(f_valid), .f_idx_o(f_idx)
  );

  vic_irq_out u_out (
    .clk_i, .rst_ni, .norm_eff_i(norm_eff), .fast_eff_i(fast_eff),
    .n_gate_i(n_gate), .irq_normal_o, .irq_fast_o
  );
endmodule

// File: tb/tb_vic_dual_class.sv
module tb_vic_dual_class;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src = '0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_n, irq_f;

  int checks = 0, errors = 0;

  vic_dual_class dut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .irq_normal_o(irq_n), .irq_fast_o(irq_f)
  );

  always #5 clk = ~clk;

  // behavioural reference model
  logic [63:0] m_pend, m_en, m_typ, m_src;
  logic [3:0]  m_prio [64];
  logic [4:0]  m_mask;
  logic [31:0] m_ctrl;
  logic        exp_n = 1'b0, exp_f = 1'b0;
  logic [31:0] exp_rd = '0;

  function automatic int pick_norm(output int pr);
    int idx = -1;
    pr = -1;
    for (int i = 0; i < 64; i++)
      if (m_pend[i] && m_en[i] && !m_typ[i] && int'(m_prio[i]) >= pr) begin
        idx = i; pr = int'(m_prio[i]);
      end
    return idx;
  endfunction

  function automatic int pick_fast();
    for (int i = 0; i < 64; i++)
      if (m_pend[i] && m_en[i] && m_typ[i]) return i;
    return -1;
  endfunction

  function automatic logic [31:0] m_read(logic [7:0] a);
    logic [63:0] ne = m_pend & m_en & ~m_typ;
    logic [63:0] fe = m_pend & m_en & m_typ;
    logic [31:0] v = '0;
    int pr, ix;
    if (a >= 8 && a <= 15) begin
      int w = 15 - int'(a);
      for (int j = 0; j < 8; j++) v[4*j +: 4] = m_prio[w*8 + j];
      return v;
    end
    case (a)
      8'd0:  return m_ctrl;
      8'd1:  return {27'd0, m_mask};
      8'd4:  return m_en[63:32];
      8'd5:  return m_en[31:0];
      8'd6:  return m_typ[63:32];
      8'd7:  return m_typ[31:0];
      8'd16: begin ix = pick_norm(pr);
               return (ix < 0) ? 32'hFFFF_FFFF : ((ix << 16) | pr); end
      8'd17: begin ix = pick_fast();
               return (ix < 0) ? 32'hFFFF_FFFF : ix; end
      8'd18: return m_pend[63:32];
      8'd19: return m_pend[31:0];
      8'd22: return ne[63:32];
      8'd23: return ne[31:0];
      8'd24: return fe[63:32];
      8'd25: return fe[31:0];
      8'h40: return 32'd4;
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend = '0; m_en = '0; m_typ = '0; m_src = '0;
      m_mask = 5'h1F; m_ctrl = '0;
      for (int i = 0; i < 64; i++) m_prio[i] = '0;
      exp_n = 1'b0; exp_f = 1'b0;
    end else begin
      logic [63:0] ne, chg;
      int ni, fi, pr;
      ne = m_pend & m_en & ~m_typ;
      exp_f = |(m_pend & m_en & m_typ);
      exp_n = 1'b0;
      for (int i = 0; i < 64; i++)
        if (ne[i] && (m_mask == 5'h1F || int'(m_prio[i]) > int'(m_mask))) exp_n = 1'b1;
      ni = pick_norm(pr);
      fi = pick_fast();
      if (req && !we) exp_rd = m_read(addr);
      chg = src ^ m_src;
      m_pend = (m_pend & ~chg) | (src & chg);
      m_src = src;
      if (req && we) begin
        case (addr)
          8'd0:  m_ctrl = wdata & 32'h017C_0000;
          8'd1:  m_mask = wdata[4:0];
          8'd2:  m_en[wdata[5:0]] = 1'b1;
          8'd3:  m_en[wdata[5:0]] = 1'b0;
          8'd4:  m_en[63:32] = wdata;
          8'd5:  m_en[31:0] = wdata;
          8'd6:  m_typ[63:32] = wdata;
          8'd7:  m_typ[31:0] = wdata;
          8'd20: m_pend[63:32] = wdata;
          8'd21: m_pend[31:0] = wdata;
          default: if (addr >= 8 && addr <= 15)
                     for (int j = 0; j < 8; j++) m_prio[(15 - int'(addr))*8 + j] = wdata[4*j +: 4];
        endcase
      end
      if (req && !we && addr == 8'd16 && ni >= 0) m_pend[ni] = 1'b0;
      if (req && !we && addr == 8'd17 && fi >= 0) m_pend[fi] = 1'b0;
    end
  end

  // per-clock comparison of the request lines
  always @(negedge clk) begin
    checks++;
    if (irq_f !== exp_f) begin
      errors++; $display("FAIL R5 irq_fast actual=%0b expected=%0b t=%0t", irq_f, exp_f, $time);
    end
    checks++;
    if (irq_n !== exp_n) begin
      errors++; $display("FAIL R6 irq_normal actual=%0b expected=%0b t=%0t", irq_n, exp_n, $time);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] lit, input string tag);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk); req = 1'b0;
    checks++;
    if (rdata !== exp_rd) begin
      errors++; $display("FAIL %s model addr=%0d actual=%h expected=%h", tag, a, rdata, exp_rd);
    end
    checks++;
    if (rdata !== lit) begin
      errors++; $display("FAIL %s addr=%0d actual=%h expected=%h", tag, a, rdata, lit);
    end
  endtask

  task automatic chk(input logic act, input logic expv, input string tag);
    checks++;
    if (act !== expv) begin
      errors++; $display("FAIL %s actual=%0b expected=%0b", tag, act, expv);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state
    chk(irq_n, 1'b0, "R1 normal low"); chk(irq_f, 1'b0, "R1 fast low");
    rd(8'd1, 32'h1F, "R1 mask");
    rd(8'd0, 32'h0, "R1 ctrl");
    rd(8'd5, 32'h0, "R1 enable");
    rd(8'd19, 32'h0, "R1 pending");
    rd(8'd15, 32'h0, "R1 prio");
    // R3 enable/disable by number
    wr(8'd2, 32'd5); wr(8'd2, 32'h47);
    rd(8'd5, 32'hA0, "R3 enable bits");
    rd(8'd2, 32'h0, "R3 ennum reads 0");
    rd(8'd3, 32'h0, "R3 disnum reads 0");
    wr(8'd3, 32'd5);
    rd(8'd5, 32'h80, "R3 disable");
    wr(8'd2, 32'd40);
    rd(8'd4, 32'h100, "R3 enable high");
    // R4 vectors, force and source views
    wr(8'd5, 32'hFFFF_FFFF); wr(8'd4, 32'hFFFF_FFFF);
    wr(8'd21, 32'h10); idle(1);
    chk(irq_n, 1'b1, "R6 bypass threshold 0x1F");
    rd(8'd19, 32'h10, "R4 source low");
    rd(8'd21, 32'h0, "R4 force reads 0");
    wr(8'd19, 32'hFFFF); wr(8'd16, 32'h3);
    rd(8'd19, 32'h10, "R9 source read-only");
    // R5 fast class
    wr(8'd7, 32'h10); idle(1);
    chk(irq_f, 1'b1, "R5 fast high"); chk(irq_n, 1'b0, "R5 normal low");
    rd(8'd25, 32'h10, "R9 fast pending");
    rd(8'd23, 32'h0, "R9 normal pending");
    wr(8'd25, 32'h0);
    rd(8'd25, 32'h10, "R9 write ignored");
    rd(8'd6, 32'h0, "R4 type high");
    // R11 fast acknowledge
    rd(8'd17, 32'd4, "R11 fast vector");
    rd(8'd19, 32'h0, "R11 pending cleared");
    rd(8'd17, 32'hFFFF_FFFF, "R11 none");
    // R6 threshold gating
    wr(8'd7, 32'h0);
    wr(8'd15, 32'h0003_0000);
    wr(8'd1, 32'h3);
    wr(8'd21, 32'h10); idle(1);
    chk(irq_n, 1'b0, "R6 prio equal threshold");
    wr(8'd1, 32'h2); idle(1);
    chk(irq_n, 1'b1, "R6 prio above threshold");
    wr(8'd1, 32'h23);
    rd(8'd1, 32'h3, "R8 mask 5 bits");
    // R7 priority words
    wr(8'd8, 32'h9009_0000);
    rd(8'd8, 32'h9009_0000, "R7 word 7");
    rd(8'd15, 32'h0003_0000, "R7 word 0");
    // R10 normal acknowledge with tie
    wr(8'd1, 32'h1F);
    wr(8'd20, 32'h9000_0000);
    rd(8'd16, 32'h003F_0009, "R10 tie higher index");
    rd(8'd16, 32'h003C_0009, "R10 second");
    rd(8'd16, 32'h0004_0003, "R10 third");
    rd(8'd16, 32'hFFFF_FFFF, "R10 none");
    // R8 control
    wr(8'd0, 32'hFFFF_FFFF);
    rd(8'd0, 32'h017C_0000, "R8 control keep");
    // R12 vector region and unknown words
    rd(8'h40, 32'd4, "R12 word 0x40");
    wr(8'h40, 32'h1234); wr(8'hBF, 32'h5678);
    rd(8'h40, 32'd4, "R12 after write");
    rd(8'h30, 32'h0, "R12 unknown");
    rd(8'd5, 32'hFFFF_FFFF, "R12 enable untouched");
    // R2 hardware source path
    src[10] = 1'b1;
    @(negedge clk); chk(irq_n, 1'b0, "R2 one edge");
    @(negedge clk); chk(irq_n, 1'b1, "R2 two edges");
    rd(8'd16, 32'h000A_0000, "R13 ack hw source");
    idle(2);
    rd(8'd19, 32'h0, "R2 no reassert on steady level");
    src[10] = 1'b0; idle(1);
    src[10] = 1'b1; idle(1);
    rd(8'd19, 32'h400, "R2 new edge");
    src[10] = 1'b0; idle(1);
    rd(8'd19, 32'h0, "R2 level low clears");
    idle(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule